// File: doc/BRIEF.md
# Thermal Limit Comparator and Event Generator

This block is the digital back end of a temperature sensor. Each time the converter presents a new signed 13-bit temperature with a valid strobe, the block stores it. The stored value is compared against three host-programmed limits: an upper bound, a lower bound and a critical bound. Three trip flags come out of that comparison and are packed with the temperature into a single readable word. A single event pin reports the combined condition. The pin can work in one of two modes: it can track the live condition, or it can latch the condition until software clears it. Its active level can be either high or low.

The host reaches a small register file through a plain address / write-data / write-enable port. Read data is combinational on the address. A shutdown input freezes the stored temperature and stops any new event from being raised, while register access keeps working. The limits are re-evaluated every cycle. As a result, writing a limit that puts the stored temperature out of bounds raises the event without waiting for the next sample.

Top module: `thermal_event_unit`

## Requirements
- R1: After reset, the configuration and all three limit registers read 0x0000, the stored temperature reads 0, and event_o sits at its inactive level, which is 1 because the reset polarity is active low.
- R2: A sample strobe while not in shutdown stores samp_temp. From the next cycle, address 4 reads {crit_trip, high_trip, low_trip, temperature[12:0]}, with the temperature in bits 12..0.
- R3: Limit registers are at address 1 (high), 2 (low) and 3 (critical). Each keeps only write bits 12..2, an 11-bit two's-complement value in 0.25 °C steps, and reads back with bits 15..13 and 1..0 at zero. Comparison uses temperature bits 12..2 as a signed value, so the two finest fraction bits are ignored.
- R4: Trip flags are bit 15 = temperature above critical, bit 14 = temperature above high, and bit 13 = temperature below low. All comparisons are strict, and the flags do not depend on any configuration bit.
- R5: Configuration at address 0 has these bits. Bit 0 is event enable. Bit 1 is the mode: 0 = comparator, 1 = interrupt. Bit 2 is the polarity: 1 = active high, 0 = active low. Bit 3 is a write-only clear that reads 0. In comparator mode the internal event state equals the condition (any trip flag set) one cycle later, so event_o changes on the second rising edge after the sample or write edge.
- R6: In interrupt mode, the event state sets when the condition goes from false to true while the block is enabled and not in shutdown. It stays set until a configuration write with bit 3 = 1. The clear wins over a set in the same cycle.
- R7: event_o shows the active level only when enable is 1 and the event state is set. Otherwise it shows the inactive level.
- R8: With a stored temperature in place, a limit write that creates the condition raises the event without any new sample, on the same two-edge timing.
- R9: While shutdown is 1, sample strobes are ignored and the stored temperature holds. The event state cannot go from clear to set. Register reads and writes still take effect.
- R10: Writes to address 4 and to addresses 5..7 change nothing. Addresses 5..7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_vld | input | 1 | New temperature sample strobe |
| samp_temp | input | 13 | Two's-complement temperature, 0.0625 °C per LSB |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| shutdown | input | 1 | Sensor shutdown |
| event_o | output | 1 | Event pin |

## Verification
Stored values appear on reg_rdata one rising edge after a sample strobe or register write. The trip flags in the data word follow on the same cycle, because they are combinational on the stored registers. event_o moves only on the second rising edge, since the event state is registered from those flags. The bench applies inputs at the falling edge and advances a reference model at each rising edge. It compares reg_rdata and event_o at the next falling edge, so every result is sampled in the cycle it is due. Random traffic mixes samples, limit writes with junk bits, mode and polarity changes, clears and shutdown.

// File: rtl/thermal_event_unit.sv
module thermal_event_unit #(
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_vld,
  input  logic [TW-1:0] samp_temp,
  input  logic [2:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  input  logic          reg_we,
  output logic [15:0]   reg_rdata,
  input  logic          shutdown,
  output logic          event_o
);
  localparam int LW = TW - 2;
  localparam logic [2:0] A_CFG = 3'd0, A_HI = 3'd1, A_LO = 3'd2, A_CR = 3'd3, A_TMP = 3'd4;

  logic [2:0]    cfg_q;
  logic [LW-1:0] lim_hi_q, lim_lo_q, lim_cr_q;
  logic [TW-1:0] temp_q;
  logic          evt_q, cond_d_q;

  wire signed [LW-1:0] t_c = $signed(temp_q[TW-1:2]);
  wire trip_cr = t_c > $signed(lim_cr_q);
  wire trip_hi = t_c > $signed(lim_hi_q);
  wire trip_lo = t_c < $signed(lim_lo_q);
  wire cond    = trip_cr | trip_hi | trip_lo;
  wire clr_wr  = reg_we && reg_addr == A_CFG && reg_wdata[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      lim_hi_q <= '0;
      lim_lo_q <= '0;
      lim_cr_q <= '0;
      temp_q   <= '0;
    end else begin
      if (samp_vld && !shutdown) temp_q <= samp_temp;
      if (reg_we) begin
        case (reg_addr)
          A_CFG:   cfg_q    <= reg_wdata[2:0];
          A_HI:    lim_hi_q <= reg_wdata[TW-1:2];
          A_LO:    lim_lo_q <= reg_wdata[TW-1:2];
          A_CR:    lim_cr_q <= reg_wdata[TW-1:2];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q    <= 1'b0;
      cond_d_q <= 1'b0;
    end else begin
      cond_d_q <= cond;
      if (!cfg_q[1])
        evt_q <= shutdown ? (evt_q & cond) : cond;
      else if (clr_wr)
        evt_q <= 1'b0;
      else if (cond && !cond_d_q && cfg_q[0] && !shutdown)
        evt_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {13'd0, cfg_q};
      A_HI:    reg_rdata = {{(16-TW){1'b0}}, lim_hi_q, 2'b00};
      A_LO:    reg_rdata = {{(16-TW){1'b0}}, lim_lo_q, 2'b00};
      A_CR:    reg_rdata = {{(16-TW){1'b0}}, lim_cr_q, 2'b00};
      A_TMP:   reg_rdata = {trip_cr, trip_hi, trip_lo, temp_q};
      default: reg_rdata = 16'd0;
    endcase
  end

  assign event_o = (cfg_q[0] && evt_q) ? cfg_q[2] : ~cfg_q[2];

  a_r9_temp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> $stable(temp_q));
  a_r9_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !evt_q) |=> !evt_q);
  a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[1] && !shutdown) |=> (evt_q == $past(cond)));
  a_r6_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1] && evt_q && !clr_wr) |=> evt_q);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1] && clr_wr) |=> !evt_q);
endmodule

// File: tb/tb_thermal_event_unit.sv
module tb_thermal_event_unit;
  logic clk = 0, rst_n = 0, samp_vld = 0, reg_we = 0, shutdown = 0;
  logic [12:0] samp_temp = '0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        event_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  thermal_event_unit dut (.clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_temp(samp_temp),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .shutdown(shutdown), .event_o(event_o));

  logic [2:0]  m_cfg;
  logic [10:0] m_hi, m_lo, m_cr;
  logic [12:0] m_t;
  logic        m_evt, m_cd;

  function automatic logic [2:0] trips();
    logic signed [10:0] t;
    t = $signed(m_t[12:2]);
    return {t > $signed(m_cr), t > $signed(m_hi), t < $signed(m_lo)};
  endfunction

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {13'd0, m_cfg};
      3'd1: return {3'd0, m_hi, 2'b00};
      3'd2: return {3'd0, m_lo, 2'b00};
      3'd3: return {3'd0, m_cr, 2'b00};
      3'd4: return {trips(), m_t};
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic exp_evt();
    return (m_cfg[0] && m_evt) ? m_cfg[2] : ~m_cfg[2];
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cfg = 0; m_hi = 0; m_lo = 0; m_cr = 0; m_t = 0; m_evt = 0; m_cd = 0;
  endtask

  task automatic model_edge();
    logic c;
    c = |trips();
    if (!m_cfg[1]) m_evt = shutdown ? (m_evt & c) : c;
    else if (reg_we && reg_addr == 0 && reg_wdata[3]) m_evt = 0;
    else if (c && !m_cd && m_cfg[0] && !shutdown) m_evt = 1;
    m_cd = c;
    if (samp_vld && !shutdown) m_t = samp_temp;
    if (reg_we)
      case (reg_addr)
        3'd0: m_cfg = reg_wdata[2:0];
        3'd1: m_hi = reg_wdata[12:2];
        3'd2: m_lo = reg_wdata[12:2];
        3'd3: m_cr = reg_wdata[12:2];
        default: ;
      endcase
  endtask

  task automatic cyc(input string tag, input logic v, input logic [12:0] t, input logic [2:0] a,
                     input logic [15:0] wd, input logic we, input logic sd);
    samp_vld = v; samp_temp = t; reg_addr = a; reg_wdata = wd; reg_we = we; shutdown = sd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({tag, " rdata"}, reg_rdata, exp_rd(a));
    check({tag, " event"}, {15'd0, event_o}, {15'd0, exp_evt()});
    samp_vld = 0; reg_we = 0;
  endtask

  task automatic idle(input string tag, input logic [2:0] a, input logic sd);
    cyc(tag, 0, 13'd0, a, 16'd0, 0, sd);
  endtask

  initial begin
    fork
      begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset cfg", reg_rdata, 16'h0000);
        check("R1 reset event idle", {15'd0, event_o}, 16'd1);
        idle("R1 temp", 3'd4, 0);
        check("R1 temp zero", reg_rdata, 16'h0000);

        cyc("R3 hi write masked", 0, 0, 3'd1, 16'hFFFF, 1, 0);
        check("R3 hi readback", reg_rdata, 16'h1FFC);
        cyc("R3 hi set", 0, 0, 3'd1, 16'h0190, 1, 0);
        cyc("R3 lo set", 0, 0, 3'd2, 16'h1F00, 1, 0);
        cyc("R3 cr set", 0, 0, 3'd3, 16'h0400, 1, 0);
        cyc("R2 sample", 1, 13'h0193, 3'd4, 0, 0, 0);
        check("R3 fraction ignored at limit", reg_rdata, 16'h0193);
        cyc("R4 above hi", 1, 13'h0194, 3'd4, 0, 0, 0);
        check("R4 high trip bit14", reg_rdata, 16'h4194);
        idle("R7 disabled idle", 3'd4, 0);
        check("R7 disabled inactive", {15'd0, event_o}, 16'd1);

        cyc("R5 enable act-high cmp", 0, 0, 3'd0, 16'h0005, 1, 0);
        idle("R5 wait", 3'd0, 0);
        check("R5 comparator active", {15'd0, event_o}, 16'd1);
        cyc("R5 drop", 1, 13'h0010, 3'd4, 0, 0, 0);
        idle("R5 drop wait", 3'd4, 0);
        check("R5 comparator cleared", {15'd0, event_o}, 16'd0);

        cyc("R8 limit write", 0, 0, 3'd1, 16'h0000, 1, 0);
        check("R8 not yet", {15'd0, event_o}, 16'd0);
        idle("R8 wait", 3'd4, 0);
        check("R8 raised by write", {15'd0, event_o}, 16'd1);

        cyc("R6 to irq act-low", 0, 0, 3'd0, 16'h0003, 1, 0);
        cyc("R6 lift hi", 0, 0, 3'd1, 16'h0400, 1, 0);
        idle("R6 still", 3'd4, 0);
        cyc("R6 new cond", 0, 0, 3'd1, 16'h0000, 1, 0);
        idle("R6 latch", 3'd4, 0);
        check("R6 latched low", {15'd0, event_o}, 16'd0);
        cyc("R6 cond gone", 0, 0, 3'd1, 16'h0400, 1, 0);
        idle("R6 hold", 3'd4, 0);
        check("R6 stays latched", {15'd0, event_o}, 16'd0);
        cyc("R6 clear", 0, 0, 3'd0, 16'h000B, 1, 0);
        check("R6 cleared", {15'd0, event_o}, 16'd1);
        check("R5 clear bit reads 0", reg_rdata, 16'h0003);

        cyc("R9 sd sample ignored", 1, 13'h1FF0, 3'd4, 0, 0, 1);
        check("R9 temp held", reg_rdata, 16'h0010);
        cyc("R9 sd write works", 0, 0, 3'd1, 16'h0000, 1, 1);
        idle("R9 no raise", 3'd1, 1);
        check("R9 no event in sd", {15'd0, event_o}, 16'd1);

        cyc("R10 write addr4", 0, 0, 3'd4, 16'hFFFF, 1, 0);
        check("R10 data unchanged", reg_rdata[12:0], 16'h0010);
        cyc("R10 write addr6", 0, 0, 3'd6, 16'hFFFF, 1, 0);
        check("R10 unused reads 0", reg_rdata, 16'h0000);

        void'($urandom(1234));
        for (int i = 0; i < 4000; i++) begin
          int op;
          logic [2:0]  a;
          logic [15:0] wd;
          op = $urandom_range(0, 9);
          a  = 3'($urandom_range(0, 7));
          wd = 16'($urandom);
          if (op inside {1, 2, 3}) wd[12:2] = 11'($signed(11'($urandom_range(0, 80))) - 40);
          case (op)
            0: cyc("R2 R4 rnd sample", 1, 13'($signed(13'($urandom_range(0, 320))) - 160), a, 0, 0, $urandom_range(0, 7) == 0);
            1, 2, 3: cyc("R3 R8 rnd limit", 0, 0, 3'(op), wd, 1, $urandom_range(0, 7) == 0);
            4: cyc("R5 R6 R7 rnd cfg", 0, 0, 3'd0, {12'd0, wd[3:0]}, 1, 0);
            5: cyc("R9 rnd sd sample", 1, 13'($urandom), a, 0, 0, 1);
            6: cyc("R10 rnd ro write", 0, 0, 3'($urandom_range(4, 7)), wd, 1, 0);
            default: idle("R5 R6 rnd idle", a, $urandom_range(0, 9) == 0);
          endcase
        end
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule